// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block generates one cross-port interrupt for each side of a two-port memory. Each side owns a single mailbox word at the top of the shared address space. The left side owns the second-highest address. The right side owns the highest. When one side writes the other side's mailbox, the owner's active-low interrupt goes low. When the owner reads its own mailbox, the interrupt returns high.

The mailbox words stay ordinary memory cells. The memory array that stores them is outside this block, so the message held in a mailbox is whatever the writer chose. The block only watches each side's chip enable, read/write, output enable, address and busy indication.

All inputs are sampled on the rising clock edge. Both flags are registered, so an event in one cycle shows on the outputs after that edge.

Top module: `dpmb_irq`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, both `l_irq_n` and `r_irq_n` are 1, whatever they held before.
- R2: If, in a cycle, the right side has `r_cs_n`=0, `r_rw_n`=0 and `r_busy_n`=1, and `r_addr` equals 2^ADDR_W-2 (0x1FFE by default), then `l_irq_n` is 0 after that edge.
- R3: If, in a cycle, the left side has `l_cs_n`=0, `l_rw_n`=0 and `l_busy_n`=1, and `l_addr` equals 2^ADDR_W-1 (0x1FFF by default), then `r_irq_n` is 0 after that edge.
- R4: If `l_cs_n`=0 and `l_oe_n`=0 with `l_addr`=2^ADDR_W-2, `l_irq_n` becomes 1 after that edge, with `l_rw_n` either 0 or 1, unless R2 sets it in the same cycle.
- R5: If `r_cs_n`=0 and `r_oe_n`=0 with `r_addr`=2^ADDR_W-1, `r_irq_n` becomes 1 after that edge, unless R3 sets it in the same cycle.
- R6: A mailbox write while the writing side's busy input is 0 leaves the target flag unchanged.
- R7: When a flag's set condition and clear condition occur in the same cycle, the flag is 0 after that edge.
- R8: A flag changes only as R1 to R7 describe. The following leave both flags unchanged: a write to any other address, a side writing its own mailbox, a mailbox access with output enable 1, and an access with chip enable 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| l_cs_n | input | 1 | Left chip enable, active low |
| l_rw_n | input | 1 | Left read/write: 1 read, 0 write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | ADDR_W | Left address |
| l_busy_n | input | 1 | Left busy indication, active low; 0 blocks left writes from setting a flag |
| r_cs_n | input | 1 | Right chip enable, active low |
| r_rw_n | input | 1 | Right read/write: 1 read, 0 write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | ADDR_W | Right address |
| r_busy_n | input | 1 | Right busy indication, active low; 0 blocks right writes from setting a flag |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
The stimulus walks a sequence of cross-side mailbox writes, each followed by the owner's read. This separates the set path from the clear path on each side. It also shows that the two flags do not interfere.

Near-miss patterns are mixed in:
- an adjacent address;
- a side writing its own mailbox;
- chip enable or output enable held high;
- busy held low.

Each of these differs from a real event by one signal, so a decode that ignores that signal shows up as a wrong flag.

Same-cycle set and clear on each flag shows the priority order. A write with output enable low shows that the clear does not depend on the read/write level. A reset while both flags are low confirms the return to idle.

// File: rtl/dpmb_pkg.sv
package dpmb_pkg;

    localparam int unsigned NUM_SIDES = 2;
    localparam int unsigned SIDE_L    = 0;
    localparam int unsigned SIDE_R    = 1;

    // per-side decode result
    typedef struct packed {
        logic post;   // write into the peer's mailbox, not blocked by busy
        logic take;   // output-enabled access of the side's own mailbox
    } mb_hit_t;

    typedef enum logic [1:0] {
        EV_HOLD = 2'd0,
        EV_SET  = 2'd1,
        EV_CLR  = 2'd2
    } flag_ev_t;

    // set wins over clear so that a fresh message is never dropped
    function automatic flag_ev_t resolve_ev(input logic set_i, input logic clr_i);
        if (set_i)
            return EV_SET;
        else if (clr_i)
            return EV_CLR;
        else
            return EV_HOLD;
    endfunction

    function automatic int unsigned peer_of(input int unsigned side);
        return (side == SIDE_L) ? SIDE_R : SIDE_L;
    endfunction

endpackage

// File: rtl/dpmb_port_dec.sv
module dpmb_port_dec
    import dpmb_pkg::*;
#(
    parameter int unsigned ADDR_W = 13,
    parameter logic [ADDR_W-1:0] OWN_BOX  = '1,
    parameter logic [ADDR_W-1:0] PEER_BOX = '0
) (
    input  logic              cs_n,
    input  logic              rw_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy_n,
    output mb_hit_t           hit
);

    logic sel;
    logic at_own;
    logic at_peer;

    always_comb begin
        sel      = ~cs_n;
        at_own   = (addr == OWN_BOX);
        at_peer  = (addr == PEER_BOX);
        hit.post = sel & ~rw_n & busy_n & at_peer;
        hit.take = sel & ~oe_n & at_own;
    end

endmodule

// File: rtl/dpmb_flag.sv
module dpmb_flag
    import dpmb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_n
);

    flag_ev_t ev;

    always_comb ev = resolve_ev(set_i, clr_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_n <= 1'b1;
        end else begin
            case (ev)
                EV_SET:  irq_n <= 1'b0;
                EV_CLR:  irq_n <= 1'b1;
                default: irq_n <= irq_n;
            endcase
        end
    end

endmodule

// File: rtl/dpmb_irq.sv
module dpmb_irq
    import dpmb_pkg::*;
#(
    parameter int unsigned ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_cs_n,
    input  logic              l_rw_n,
    input  logic              l_oe_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_busy_n,
    input  logic              r_cs_n,
    input  logic              r_rw_n,
    input  logic              r_oe_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_busy_n,
    output logic              l_irq_n,
    output logic              r_irq_n
);

    // top two locations of the array serve as mailboxes
    localparam logic [ADDR_W-1:0] L_BOX = {{(ADDR_W-1){1'b1}}, 1'b0};
    localparam logic [ADDR_W-1:0] R_BOX = {ADDR_W{1'b1}};

    logic              cs_n_a   [NUM_SIDES];
    logic              rw_n_a   [NUM_SIDES];
    logic              oe_n_a   [NUM_SIDES];
    logic [ADDR_W-1:0] addr_a   [NUM_SIDES];
    logic              busy_n_a [NUM_SIDES];
    mb_hit_t           hit_a    [NUM_SIDES];
    logic              irq_n_a  [NUM_SIDES];

    always_comb begin
        cs_n_a[SIDE_L]   = l_cs_n;
        rw_n_a[SIDE_L]   = l_rw_n;
        oe_n_a[SIDE_L]   = l_oe_n;
        addr_a[SIDE_L]   = l_addr;
        busy_n_a[SIDE_L] = l_busy_n;
        cs_n_a[SIDE_R]   = r_cs_n;
        rw_n_a[SIDE_R]   = r_rw_n;
        oe_n_a[SIDE_R]   = r_oe_n;
        addr_a[SIDE_R]   = r_addr;
        busy_n_a[SIDE_R] = r_busy_n;
    end

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        localparam logic [ADDR_W-1:0] OWN  = (s == SIDE_L) ? L_BOX : R_BOX;
        localparam logic [ADDR_W-1:0] PEER = (s == SIDE_L) ? R_BOX : L_BOX;
        localparam int unsigned       P    = peer_of(s);

        dpmb_port_dec #(
            .ADDR_W   (ADDR_W),
            .OWN_BOX  (OWN),
            .PEER_BOX (PEER)
        ) u_dec (
            .cs_n   (cs_n_a[s]),
            .rw_n   (rw_n_a[s]),
            .oe_n   (oe_n_a[s]),
            .addr   (addr_a[s]),
            .busy_n (busy_n_a[s]),
            .hit    (hit_a[s])
        );

        dpmb_flag u_flag (
            .clk   (clk),
            .rst   (rst),
            .set_i (hit_a[P].post),
            .clr_i (hit_a[s].take),
            .irq_n (irq_n_a[s])
        );
    end

    assign l_irq_n = irq_n_a[SIDE_L];
    assign r_irq_n = irq_n_a[SIDE_R];

endmodule

// File: rtl/dpmb_irq_chk.sv
module dpmb_irq_chk #(
    parameter int unsigned ADDR_W = 13
) (
    input logic              clk,
    input logic              rst,
    input logic              l_cs_n,
    input logic              l_rw_n,
    input logic              l_oe_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic              l_busy_n,
    input logic              r_cs_n,
    input logic              r_rw_n,
    input logic              r_oe_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic              r_busy_n,
    input logic              l_irq_n,
    input logic              r_irq_n
);

    localparam logic [ADDR_W-1:0] LB = {{(ADDR_W-1){1'b1}}, 1'b0};
    localparam logic [ADDR_W-1:0] RB = {ADDR_W{1'b1}};

    logic r_wr_lb, l_wr_rb, l_rd_lb, r_rd_rb;
    assign r_wr_lb = !r_cs_n && !r_rw_n && (r_addr == LB);
    assign l_wr_rb = !l_cs_n && !l_rw_n && (l_addr == RB);
    assign l_rd_lb = !l_cs_n && !l_oe_n && (l_addr == LB);
    assign r_rd_rb = !r_cs_n && !r_oe_n && (r_addr == RB);

    // R1
    a_r1_reset_idle: assert property (@(posedge clk)
        $past(rst) |-> (l_irq_n && r_irq_n));

    // R2, R7
    a_r2_set_left: assert property (@(posedge clk) disable iff (rst)
        (r_wr_lb && r_busy_n) |=> !l_irq_n);

    // R3, R7
    a_r3_set_right: assert property (@(posedge clk) disable iff (rst)
        (l_wr_rb && l_busy_n) |=> !r_irq_n);

    // R4
    a_r4_clear_left: assert property (@(posedge clk) disable iff (rst)
        (l_rd_lb && !(r_wr_lb && r_busy_n)) |=> l_irq_n);

    // R5
    a_r5_clear_right: assert property (@(posedge clk) disable iff (rst)
        (r_rd_rb && !(l_wr_rb && l_busy_n)) |=> r_irq_n);

    // R6
    a_r6_busy_blocks_left: assert property (@(posedge clk) disable iff (rst)
        (r_wr_lb && !r_busy_n && !l_rd_lb) |=> $stable(l_irq_n));

    a_r6_busy_blocks_right: assert property (@(posedge clk) disable iff (rst)
        (l_wr_rb && !l_busy_n && !r_rd_rb) |=> $stable(r_irq_n));

    // R8
    a_r8_hold_left: assert property (@(posedge clk) disable iff (rst)
        (!(r_wr_lb && r_busy_n) && !l_rd_lb) |=> $stable(l_irq_n));

    a_r8_hold_right: assert property (@(posedge clk) disable iff (rst)
        (!(l_wr_rb && l_busy_n) && !r_rd_rb) |=> $stable(r_irq_n));

endmodule

bind dpmb_irq dpmb_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .l_cs_n   (l_cs_n),
    .l_rw_n   (l_rw_n),
    .l_oe_n   (l_oe_n),
    .l_addr   (l_addr),
    .l_busy_n (l_busy_n),
    .r_cs_n   (r_cs_n),
    .r_rw_n   (r_rw_n),
    .r_oe_n   (r_oe_n),
    .r_addr   (r_addr),
    .r_busy_n (r_busy_n),
    .l_irq_n  (l_irq_n),
    .r_irq_n  (r_irq_n)
);

// File: tb/dpmb_irq_tb.sv
module dpmb_irq_tb;

    localparam int unsigned AW = 13;
    localparam logic [AW-1:0] LM = 13'h1FFE;
    localparam logic [AW-1:0] RM = 13'h1FFF;

    typedef struct packed {
        logic          cs_n;
        logic          rw_n;
        logic          oe_n;
        logic [AW-1:0] addr;
        logic          busy_n;
    } side_t;

    typedef struct packed {
        side_t      l;
        side_t      r;
        logic       el;
        logic       er;
        logic [3:0] req;
    } vec_t;

    function automatic side_t s_idle();
        return '{cs_n: 1'b1, rw_n: 1'b1, oe_n: 1'b1, addr: '0, busy_n: 1'b1};
    endfunction
    function automatic side_t s_wr(input logic [AW-1:0] a, input logic b);
        return '{cs_n: 1'b0, rw_n: 1'b0, oe_n: 1'b1, addr: a, busy_n: b};
    endfunction
    function automatic side_t s_rd(input logic [AW-1:0] a);
        return '{cs_n: 1'b0, rw_n: 1'b1, oe_n: 1'b0, addr: a, busy_n: 1'b1};
    endfunction
    function automatic side_t s_raw(input logic c, input logic w, input logic o,
                                    input logic [AW-1:0] a);
        return '{cs_n: c, rw_n: w, oe_n: o, addr: a, busy_n: 1'b1};
    endfunction

    localparam int NV = 18;
    // flags expected after each vector's clock edge; state carries forward
    localparam vec_t VEC [NV] = '{
        '{s_idle(),          s_idle(),          1'b1, 1'b1, 4'd8}, // R8 idle
        '{s_idle(),          s_wr(LM, 1'b1),    1'b0, 1'b1, 4'd2}, // R2
        '{s_idle(),          s_idle(),          1'b0, 1'b1, 4'd8}, // R8 hold
        '{s_wr(RM, 1'b1),    s_idle(),          1'b0, 1'b0, 4'd3}, // R3
        '{s_rd(LM),          s_idle(),          1'b1, 1'b0, 4'd4}, // R4
        '{s_idle(),          s_rd(RM),          1'b1, 1'b1, 4'd5}, // R5
        '{s_idle(),          s_wr(LM, 1'b0),    1'b1, 1'b1, 4'd6}, // R6 right busy
        '{s_wr(RM, 1'b0),    s_idle(),          1'b1, 1'b1, 4'd6}, // R6 left busy
        '{s_idle(),          s_wr(13'h1FFD, 1'b1), 1'b1, 1'b1, 4'd8}, // R8 other addr
        '{s_wr(LM, 1'b1),    s_wr(RM, 1'b1),    1'b1, 1'b1, 4'd8}, // R8 own mailbox
        '{s_idle(),          s_wr(LM, 1'b1),    1'b0, 1'b1, 4'd2}, // R2 again
        '{s_raw(1'b0, 1'b1, 1'b1, LM), s_idle(), 1'b0, 1'b1, 4'd8}, // R8 oe high
        '{s_raw(1'b1, 1'b1, 1'b0, LM), s_idle(), 1'b0, 1'b1, 4'd8}, // R8 cs high
        '{s_raw(1'b0, 1'b0, 1'b0, LM), s_idle(), 1'b1, 1'b1, 4'd4}, // R4 rw low
        '{s_rd(LM),          s_wr(LM, 1'b1),    1'b0, 1'b1, 4'd7}, // R7 left
        '{s_wr(RM, 1'b1),    s_rd(RM),          1'b0, 1'b0, 4'd7}, // R7 right
        '{s_idle(),          s_wr(13'h0FFE, 1'b1), 1'b0, 1'b0, 4'd8}, // R8 upper bit
        '{s_rd(LM),          s_rd(RM),          1'b1, 1'b1, 4'd5}  // R4 and R5
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    side_t         drv_l, drv_r;
    logic          l_irq_n, r_irq_n;
    int            n_chk = 0;
    int            n_bad = 0;
    bit            done  = 1'b0;

    always #2 clk = ~clk;

    dpmb_irq #(.ADDR_W(AW)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .l_cs_n   (drv_l.cs_n),
        .l_rw_n   (drv_l.rw_n),
        .l_oe_n   (drv_l.oe_n),
        .l_addr   (drv_l.addr),
        .l_busy_n (drv_l.busy_n),
        .r_cs_n   (drv_r.cs_n),
        .r_rw_n   (drv_r.rw_n),
        .r_oe_n   (drv_r.oe_n),
        .r_addr   (drv_r.addr),
        .r_busy_n (drv_r.busy_n),
        .l_irq_n  (l_irq_n),
        .r_irq_n  (r_irq_n)
    );

    task automatic check(input int req, input logic el, input logic er);
        n_chk++;
        if (l_irq_n !== el || r_irq_n !== er) begin
            n_bad++;
            $display("FAIL R%0d: l_irq_n=%b r_irq_n=%b expected %b %b",
                     req, l_irq_n, r_irq_n, el, er);
        end
    endtask

    task automatic step(input side_t l, input side_t r);
        drv_l = l;
        drv_r = r;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        drv_l = s_idle();
        drv_r = s_idle();
        repeat (3) @(negedge clk);
        check(1, 1'b1, 1'b1);             // R1 during reset
        rst = 1'b0;
        step(s_idle(), s_idle());
        check(1, 1'b1, 1'b1);             // R1 first cycle after reset

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].l, VEC[i].r);
            check(int'(VEC[i].req), VEC[i].el, VEC[i].er);
        end

        // R1: reset drops both pending flags
        step(s_wr(RM, 1'b1), s_wr(LM, 1'b1));
        check(3, 1'b0, 1'b0);
        rst = 1'b1;
        step(s_wr(RM, 1'b1), s_wr(LM, 1'b1));
        check(1, 1'b1, 1'b1);
        rst = 1'b0;
        step(s_idle(), s_idle());
        check(1, 1'b1, 1'b1);

        // R6: busy on the writer holds a flag that is already low
        step(s_idle(), s_wr(LM, 1'b1));
        step(s_wr(RM, 1'b0), s_wr(LM, 1'b0));
        check(6, 1'b0, 1'b1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule